// File: doc/BRIEF.md
# Byte-Maskable Synchronous Write Array

This block is a single-port synchronous storage array whose word is split into byte lanes. All of its inputs are sampled on the rising clock edge. A write cycle stores some or all lanes of the addressed word and completes in that same cycle, with no handshake. The lanes to write come from one of two sources. A global write stores every lane. A byte-write enable stores only the lanes whose individual select bits are set.

A selected cycle that is not a write is a read. The stored word at the sampled address appears on the raw read output one edge later, ready for an external output stage. Burst address generation and output register timing are not part of this block.

A chip enable qualifies every access. A sleep input places the array in a low-power hold state. In that state no access happens, the stored contents stay intact, and the read output stays frozen. The word width is a parameter. Widths that divide by 8 use 8-bit lanes. Otherwise each lane is 9 bits wide so that it carries a parity bit.

Top module: `byteWriteArray`

## Requirements
- R1: A lane is written only in a cycle where chipEn is high, sleep is low, and either globalWr is high or byteWrEn is high together with that lane's bit in laneSel. In particular, byteWrEn high with laneSel all zero writes nothing.
- R2: With byteWrEn high and globalWr low, every lane whose laneSel bit is set is written in the same cycle, from one lane up to all lanes, and the unselected lanes keep their old contents.
- R3: With chipEn high, sleep low and globalWr high, all lanes of the addressed word are written from wrData, whatever byteWrEn and laneSel hold.
- R4: When chipEn is low, no lane is written and rdData holds its value.
- R5: When sleep is high, no lane is written, rdData holds its value, and every stored word keeps its contents across the sleep interval.
- R6: A cycle with chipEn high, sleep low, globalWr low and byteWrEn low is a read. After that rising edge, rdData equals the word stored at the sampled address.
- R7: Lane k holds data bits [k*LW+LW-1 : k*LW], where LW is 8 when the word width divides by 8 and 9 otherwise. laneSel bit k controls lane k. With the default 32-bit word there are four 8-bit lanes.
- R8: After reset, rdData is zero.
- R9: A write cycle leaves rdData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the read register |
| chipEn | input | 1 | Qualifies any access in the cycle |
| sleep | input | 1 | Low-power hold; blocks access, keeps contents |
| globalWr | input | 1 | Writes all lanes of the addressed word |
| byteWrEn | input | 1 | Enables per-lane writes chosen by laneSel |
| laneSel | input | DATA_W/LW | Per-lane write select |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Raw read word to the output stage |

## Verification
Two kinds of control can meet in one cycle. The first is a global write together with a byte-write enable and a partial lane select. The second is a write request, or a read, arriving while sleep or a deasserted chip enable is in force. The bench drives each of these combinations deliberately. It then reads the affected word back in a later cycle and compares every lane with a reference model built from the requirements: the global write must win over the lane mask, and sleep or a deasserted chip enable must win over any write. In the blocked cycles the bench also checks that the read output has not moved.

// File: rtl/byteWriteArray_pkg.sv
package byteWriteArray_pkg;

  // Cycle strobes handed from control to the datapath.
  typedef struct packed {
    logic rdEn;   // capture addressed word into the read register
    logic wrEn;   // at least the lane mask may store this cycle
  } arrayStrobes_t;

  function automatic int unsigned laneWidthOf(input int unsigned dataW);
    return (dataW % 8 == 0) ? 8 : 9;
  endfunction

endpackage

// File: rtl/byteWriteArrayCtrl.sv
module byteWriteArrayCtrl
  import byteWriteArray_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipEn,
  input  logic                 sleep,
  input  logic                 globalWr,
  input  logic                 byteWrEn,
  input  logic [NUM_LANES-1:0] laneSel,
  output arrayStrobes_t        strobes,
  output logic [NUM_LANES-1:0] laneWr
);

  logic active;
  logic wrRequest;
  logic wrCycle;
  logic [NUM_LANES-1:0] maskSel;

  // Sleep and chip enable gate everything; sleep dominates.
  assign active    = chipEn && !sleep;
  assign wrRequest = globalWr || byteWrEn;
  assign wrCycle   = active && wrRequest;

  // Global write overrides the per-lane selects.
  always_comb begin
    if (globalWr) begin
      maskSel = '1;
    end else if (byteWrEn) begin
      maskSel = laneSel;
    end else begin
      maskSel = '0;
    end
  end

  always_comb begin
    strobes.wrEn = wrCycle;
    strobes.rdEn = active && !wrRequest;
    laneWr       = wrCycle ? maskSel : '0;
  end

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (laneWr == '0 && !strobes.rdEn)); // R5

  AST_CE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (laneWr == '0 && !strobes.rdEn)); // R4

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !sleep && globalWr) |-> (&laneWr)); // R3

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |-> (laneWr == '0)); // R6

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_laneChk
    AST_LANE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
      laneWr[k] |-> (globalWr || (byteWrEn && laneSel[k]))); // R1
  end

endmodule

// File: rtl/byteWriteLane.sv
module byteWriteLane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [LANE_W-1:0] rdOut
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];

  // Storage carries no reset so that contents survive any hold state.
  always_ff @(posedge clk) begin
    if (wrEn) begin
      store[addr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOut <= '0;
    end else if (rdEn) begin
      rdOut <= store[addr];
    end
  end

endmodule

// File: rtl/byteWriteArrayData.sv
module byteWriteArrayData
  import byteWriteArray_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arrayStrobes_t        strobes,
  input  logic [NUM_LANES-1:0] laneWr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] laneOut;

    byteWriteLane #(
      .LANE_W (LANE_W),
      .ADDR_W (ADDR_W)
    ) i_lane (
      .clk    (clk),
      .rstN   (rstN),
      .addr   (addr),
      .wrData (wrData[k*LANE_W +: LANE_W]),
      .wrEn   (strobes.wrEn && laneWr[k]),
      .rdEn   (strobes.rdEn),
      .rdOut  (laneOut)
    );

    assign rdData[k*LANE_W +: LANE_W] = laneOut;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> $stable(rdData)); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdEn && strobes.wrEn)); // R6

endmodule

// File: rtl/byteWriteArray.sv
module byteWriteArray
  import byteWriteArray_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned LANE_W    = laneWidthOf(DATA_W),
  localparam int unsigned NUM_LANES = DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipEn,
  input  logic                 sleep,
  input  logic                 globalWr,
  input  logic                 byteWrEn,
  input  logic [NUM_LANES-1:0] laneSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);

  arrayStrobes_t        strobes;
  logic [NUM_LANES-1:0] laneWr;

  byteWriteArrayCtrl #(
    .NUM_LANES (NUM_LANES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEn   (chipEn),
    .sleep    (sleep),
    .globalWr (globalWr),
    .byteWrEn (byteWrEn),
    .laneSel  (laneSel),
    .strobes  (strobes),
    .laneWr   (laneWr)
  );

  byteWriteArrayData #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .laneWr  (laneWr),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  AST_SLEEP_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(rdData)); // R5

  AST_CE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> $stable(rdData)); // R4

endmodule

// File: tb/test_byteWriteArray.sv
`timescale 1ns/1ps
module test_byteWriteArray;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int LW     = 8;
  localparam int NL     = DATA_W / LW;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipEn = 1'b0;
  logic              sleep = 1'b0;
  logic              globalWr = 1'b0;
  logic              byteWrEn = 1'b0;
  logic [NL-1:0]     laneSel = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] lastOut = '0;
  logic [DATA_W-1:0] expQ [$];
  string             tagQ [$];

  always #4 clk = ~clk;

  byteWriteArray #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_byteWriteArray (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .sleep(sleep),
    .globalWr(globalWr), .byteWrEn(byteWrEn), .laneSel(laneSel),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each cycle's read output against the scoreboard.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      check(rdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  // Driver: applies one cycle and pushes the expected read output.
  task automatic cyc(input logic ce, input logic slp, input logic gw,
                     input logic bw, input logic [NL-1:0] sel,
                     input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input string tag);
    chipEn = ce; sleep = slp; globalWr = gw; byteWrEn = bw;
    laneSel = sel; addr = a; wrData = d;
    @(posedge clk);
    if (ce && !slp) begin
      if (gw || bw) begin
        for (int k = 0; k < NL; k++) begin
          if (gw || sel[k]) model[a][k*LW +: LW] = d[k*LW +: LW];
        end
      end else begin
        lastOut = model[a];
      end
    end
    expQ.push_back(lastOut);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    cyc(1, 0, 0, 0, '0, a, 32'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    check(rdData, '0, "R8 reset");
    rstN = 1'b1;
    @(negedge clk);

    // Fill the whole array with global writes (R3).
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 0, 1, 0, '0, i[ADDR_W-1:0], {8'(i), 8'hA5, 8'(i ^ 7), 8'h3C}, "R9 gw fill");
    end
    for (int i = 0; i < DEPTH; i++) rd(i[ADDR_W-1:0], "R3 R6 read fill");

    // Single lane writes, lane mapping (R1, R7).
    for (int k = 0; k < NL; k++) begin
      cyc(1, 0, 0, 1, NL'(1 << k), 6'd5, 32'hDEAD_BEEF, "R1 R7 one lane");
      rd(6'd5, "R7 lane position");
    end
    // Several lanes at once (R2).
    cyc(1, 0, 0, 1, 4'b0110, 6'd9, 32'h1122_3344, "R2 two lanes");
    rd(6'd9, "R2 two lanes");
    cyc(1, 0, 0, 1, 4'b1111, 6'd9, 32'h5566_7788, "R2 all lanes");
    rd(6'd9, "R2 all lanes");
    // Select without byte enable is a read; nothing written (R1).
    cyc(1, 0, 0, 0, 4'b1111, 6'd9, 32'hFFFF_FFFF, "R1 sel no enable");
    rd(6'd9, "R1 sel no enable");
    // Byte enable with empty mask writes nothing (R1).
    cyc(1, 0, 0, 1, 4'b0000, 6'd9, 32'h0BAD_0BAD, "R1 empty mask");
    rd(6'd9, "R1 empty mask");
    // Global write overrides a partial mask (R3).
    cyc(1, 0, 1, 1, 4'b0100, 6'd12, 32'hCAFE_F00D, "R3 gw override");
    rd(6'd12, "R3 gw override");
    // Chip enable low blocks write and read (R4).
    rd(6'd1, "R6 prime");
    cyc(0, 0, 1, 0, '0, 6'd12, 32'h0, "R4 ce low write");
    cyc(0, 0, 0, 0, '0, 6'd3, 32'h0, "R4 ce low read");
    rd(6'd12, "R4 contents kept");
    // Sleep blocks writes and reads, contents kept (R5).
    cyc(1, 1, 1, 0, '0, 6'd12, 32'h0, "R5 sleep gw");
    cyc(1, 1, 0, 1, 4'b1111, 6'd9, 32'h0, "R5 sleep bw");
    cyc(1, 1, 0, 0, '0, 6'd2, 32'h0, "R5 sleep read");
    rd(6'd12, "R5 kept after sleep");
    rd(6'd9, "R5 kept after sleep");
    // Mixed pseudo-random traffic.
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3] | lfsr[4], lfsr[5] & lfsr[6] & lfsr[7], lfsr[8] & lfsr[9],
          lfsr[10], lfsr[14:11], lfsr[20:15], lfsr ^ 32'h5A5A_0F0F, "R2 R6 mixed");
    end

    while (expQ.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule